// File: doc/BRIEF.md
# Floating-point set-on-compare unit

This block evaluates one ordering predicate between two IEEE-754 operands and loads the outcome into a single-bit floating-point status flag. A precision select chooses the operand format. In single precision each operand is one 32-bit register word. In double precision each operand is an even/odd register pair joined into 64 bits, with the even register as the upper word and the odd register as the lower word.

A 3-bit condition code picks one of six predicates. The flag register captures the result only on a clock edge where the valid strobe is high. At all other times it keeps its previous value.

Not-a-Number operands follow a fixed rule and raise no exception. Signed zeros are treated as equal. Ordering uses sign-magnitude values, so the magnitude order is reversed between two negative operands. The block contains no arithmetic, rounding or format conversion.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Condition codes select the predicate A op B: 3'd0 less-than, 3'd1 greater-than, 3'd2 equal, 3'd3 less-or-equal, 3'd4 greater-or-equal, 3'd5 not-equal. The flag becomes 1 when the predicate holds and 0 when it does not.
- R2: Condition codes 3'd6 and 3'd7 load 0 into the flag.
- R3: With `dbl_i`=0, each operand is the single-precision value in its even (`_ev_i`) word, with sign at bit 31, an 8-bit exponent at bits 30:23 and a 23-bit fraction at bits 22:0. The odd (`_od_i`) words have no effect on the result.
- R4: With `dbl_i`=1, each operand is the 64-bit double {even word, odd word}, with sign at bit 63, an 11-bit exponent at bits 62:52 and a 52-bit fraction at bits 51:0. A difference confined to the odd word changes the result.
- R5: +0 and -0 are equal: EQ, LE and GE are true, and LT, GT and NE are false.
- R6: If either operand is a NaN (exponent all ones with a nonzero fraction), every predicate gives 0 except not-equal, which gives 1.
- R7: A negative operand orders below a positive one. Between two negative operands, the one with the larger magnitude is the smaller value.
- R8: The flag changes only on a rising clock edge where `vld_i` is 1, and becomes visible after that edge. Without `vld_i` the flag holds its value whatever the other inputs do.
- R9: An active-low asynchronous reset clears the flag to 0.
- R10: An infinity orders beyond every finite value of the same sign: +inf is greater than any positive finite value, and -inf is less than any negative finite value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Strobe that loads a new compare result |
| dbl_i | input | 1 | 1 selects double precision, 0 selects single precision |
| cond_i | input | 3 | Predicate code |
| opa_ev_i | input | 32 | Operand A, even register word |
| opa_od_i | input | 32 | Operand A, odd register word |
| opb_ev_i | input | 32 | Operand B, even register word |
| opb_od_i | input | 32 | Operand B, odd register word |
| flag_o | output | 1 | Registered status flag |

## Verification
The bench targets the following corner cases, and each one catches a specific kind of faulty design:
- **Signed zeros:** a design that compares raw bit patterns reports -0 as less than +0.
- **Two negatives:** a design that compares magnitudes without regard to sign gets the order backwards.
- **Unordered operands:** NaN inputs must make every predicate false except not-equal. A fault in the unordered path either makes not-equal false or lets one of the ordered predicates through.
- **Precision select:** single-precision vectors carry garbage in the odd words, and double-precision vectors differ only in the odd word. One double-precision NaN has an upper word that looks like an infinity. A design that reads the wrong word, or that classifies using the upper word only, returns the wrong flag.
- **Flag hold:** the bench checks that the flag stays put while `vld_i` is low, and that it clears on reset.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int WORD_W = 32;
    localparam int MAG_W  = 2 * WORD_W - 1;

    typedef enum logic [2:0] {
        CMP_LT = 3'd0,
        CMP_GT = 3'd1,
        CMP_EQ = 3'd2,
        CMP_LE = 3'd3,
        CMP_GE = 3'd4,
        CMP_NE = 3'd5
    } cmp_cond_e;

    // decoded view of one operand, aligned for ordering
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    // relation of operand A to operand B
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic unord;
    } fp_rel_t;

    typedef struct packed {
        logic flag;
    } fcmp_state_t;

endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int SP_EXP_W = 8,
    parameter int DP_EXP_W = 11
) (
    input  logic              dbl_i,
    input  logic [WORD_W-1:0] ev_i,
    input  logic [WORD_W-1:0] od_i,
    output fp_class_t         cls_o
);
    localparam int DW       = 2 * WORD_W;
    localparam int SP_MAN_W = WORD_W - 1 - SP_EXP_W;
    localparam int DP_MAN_W = DW - 1 - DP_EXP_W;
    localparam int SP_PAD   = MAG_W - (WORD_W - 1);

    logic [DW-1:0]       dp_word;
    logic [SP_EXP_W-1:0] sp_exp;
    logic [SP_MAN_W-1:0] sp_man;
    logic [DP_EXP_W-1:0] dp_exp;
    logic [DP_MAN_W-1:0] dp_man;

    always_comb begin
        dp_word = {ev_i, od_i};
        sp_exp  = ev_i[WORD_W-2 -: SP_EXP_W];
        sp_man  = ev_i[SP_MAN_W-1:0];
        dp_exp  = dp_word[DW-2 -: DP_EXP_W];
        dp_man  = dp_word[DP_MAN_W-1:0];
        cls_o.sign = ev_i[WORD_W-1];
        if (dbl_i) begin
            cls_o.is_nan  = (&dp_exp) && (|dp_man);
            cls_o.is_zero = ~|dp_word[DW-2:0];
            cls_o.mag     = dp_word[DW-2:0];
        end else begin
            cls_o.is_nan  = (&sp_exp) && (|sp_man);
            cls_o.is_zero = ~|ev_i[WORD_W-2:0];
            cls_o.mag     = {{SP_PAD{1'b0}}, ev_i[WORD_W-2:0]};
        end
    end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_class_t a_i,
    input  fp_class_t b_i,
    output fp_rel_t   rel_o
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a_i.mag < b_i.mag;
        mag_eq = a_i.mag == b_i.mag;
        rel_o  = '0;
        if (a_i.is_nan || b_i.is_nan) begin
            rel_o.unord = 1'b1;
        end else if (a_i.is_zero && b_i.is_zero) begin
            rel_o.eq = 1'b1;
        end else if (a_i.sign != b_i.sign) begin
            rel_o.lt = a_i.sign;
            rel_o.gt = b_i.sign;
        end else if (mag_eq) begin
            rel_o.eq = 1'b1;
        end else if (!a_i.sign) begin
            rel_o.lt = mag_lt;
            rel_o.gt = !mag_lt;
        end else begin
            rel_o.lt = !mag_lt;
            rel_o.gt = mag_lt;
        end
    end

endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
    import fcmp_pkg::*;
(
    input  logic [2:0] cond_i,
    input  fp_rel_t    rel_i,
    output logic       hit_o
);
    always_comb begin
        unique case (cond_i)
            CMP_LT:  hit_o = rel_i.lt;
            CMP_GT:  hit_o = rel_i.gt;
            CMP_EQ:  hit_o = rel_i.eq;
            CMP_LE:  hit_o = rel_i.lt | rel_i.eq;
            CMP_GE:  hit_o = rel_i.gt | rel_i.eq;
            CMP_NE:  hit_o = !rel_i.eq;
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int SP_EXP_W = 8,
    parameter int DP_EXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              dbl_i,
    input  logic [2:0]        cond_i,
    input  logic [WORD_W-1:0] opa_ev_i,
    input  logic [WORD_W-1:0] opa_od_i,
    input  logic [WORD_W-1:0] opb_ev_i,
    input  logic [WORD_W-1:0] opb_od_i,
    output logic              flag_o
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ev_w [N_OPS];
    logic [WORD_W-1:0] od_w [N_OPS];
    fp_class_t         cls  [N_OPS];
    fp_rel_t           rel;
    logic              hit;
    fcmp_state_t       st_d;
    fcmp_state_t       st_q;

    always_comb begin
        ev_w[0] = opa_ev_i;
        od_w[0] = opa_od_i;
        ev_w[1] = opb_ev_i;
        od_w[1] = opb_od_i;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
        fcmp_unpack #(
            .SP_EXP_W (SP_EXP_W),
            .DP_EXP_W (DP_EXP_W)
        ) u_unpack (
            .dbl_i (dbl_i),
            .ev_i  (ev_w[g]),
            .od_i  (od_w[g]),
            .cls_o (cls[g])
        );
    end

    fcmp_order u_order (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .rel_o (rel)
    );

    fcmp_pred u_pred (
        .cond_i (cond_i),
        .rel_i  (rel),
        .hit_o  (hit)
    );

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            st_d.flag = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vld_i,
    input logic        dbl_i,
    input logic [2:0]  cond_i,
    input logic [31:0] opa_ev_i,
    input logic [31:0] opa_od_i,
    input logic [31:0] opb_ev_i,
    input logic [31:0] opb_od_i,
    input logic        flag_o
);
    function automatic logic nan_f(input logic d, input logic [31:0] ev, input logic [31:0] od);
        if (d) return (ev[30:20] == 11'h7FF) && ((ev[19:0] != 20'h0) || (od != 32'h0));
        return (ev[30:23] == 8'hFF) && (ev[22:0] != 23'h0);
    endfunction

    function automatic logic zero_f(input logic d, input logic [31:0] ev, input logic [31:0] od);
        if (d) return (ev[30:0] == 31'h0) && (od == 32'h0);
        return ev[30:0] == 31'h0;
    endfunction

    logic any_nan;
    logic both_zero;
    assign any_nan   = nan_f(dbl_i, opa_ev_i, opa_od_i) || nan_f(dbl_i, opb_ev_i, opb_od_i);
    assign both_zero = zero_f(dbl_i, opa_ev_i, opa_od_i) && zero_f(dbl_i, opb_ev_i, opb_od_i);

    // R8: no strobe, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(flag_o));

    // R6: unordered operands make not-equal true
    p_nan_ne_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && any_nan && cond_i == 3'd5 |=> flag_o);

    // R6: unordered operands make every other predicate false
    p_nan_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && any_nan && cond_i != 3'd5 |=> !flag_o);

    // R5: signed zeros are equal
    p_zero_eq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && both_zero && cond_i == 3'd2 |=> flag_o);

    // R2: unused codes load zero
    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i && cond_i[2] && cond_i[1] |=> !flag_o);

    // R9: reset holds the flag low
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !flag_o);

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (vld_i),
    .dbl_i    (dbl_i),
    .cond_i   (cond_i),
    .opa_ev_i (opa_ev_i),
    .opa_od_i (opa_od_i),
    .opb_ev_i (opb_ev_i),
    .opb_od_i (opb_od_i),
    .flag_o   (flag_o)
);

// File: tb/tb_fcmp_flag_unit.sv
module tb_fcmp_flag_unit;

    typedef struct packed {
        logic        dbl;
        logic [2:0]  cond;
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        // single precision; odd words carry garbage (R3)
        '{1'b0, 3'd0, 64'h3F800000_DEADBEEF, 64'h40000000_12345678, 1'b1, 4'd1}, // R1 1<2
        '{1'b0, 3'd1, 64'h3F800000_DEADBEEF, 64'h40000000_12345678, 1'b0, 4'd1}, // R1 1>2
        '{1'b0, 3'd2, 64'h40000000_00000001, 64'h40000000_FFFFFFFF, 1'b1, 4'd1}, // R1 2==2
        '{1'b0, 3'd3, 64'h40000000_DEADBEEF, 64'h40000000_00000000, 1'b1, 4'd1}, // R1 2<=2
        '{1'b0, 3'd4, 64'h3F800000_DEADBEEF, 64'h40000000_00000000, 1'b0, 4'd1}, // R1 1>=2
        '{1'b0, 3'd5, 64'h3F800000_DEADBEEF, 64'h40000000_00000000, 1'b1, 4'd1}, // R1 1!=2
        '{1'b0, 3'd0, 64'hC0000000_00000000, 64'hBF800000_00000000, 1'b1, 4'd7}, // R7 -2<-1
        '{1'b0, 3'd1, 64'hC0000000_00000000, 64'hBF800000_00000000, 1'b0, 4'd7}, // R7 -2>-1
        '{1'b0, 3'd0, 64'hBF800000_00000000, 64'h3F800000_00000000, 1'b1, 4'd7}, // R7 -1<1
        '{1'b0, 3'd2, 64'h00000000_00000000, 64'h80000000_00000000, 1'b1, 4'd5}, // R5 +0==-0
        '{1'b0, 3'd5, 64'h00000000_00000000, 64'h80000000_00000000, 1'b0, 4'd5}, // R5 +0!=-0
        '{1'b0, 3'd0, 64'h80000000_00000000, 64'h00000000_00000000, 1'b0, 4'd5}, // R5 -0<+0
        '{1'b0, 3'd2, 64'h7FC00000_00000000, 64'h7FC00000_00000000, 1'b0, 4'd6}, // R6 NaN==NaN
        '{1'b0, 3'd5, 64'h7FC00000_00000000, 64'h3F800000_00000000, 1'b1, 4'd6}, // R6 NaN!=1
        '{1'b0, 3'd3, 64'h3F800000_00000000, 64'hFF800001_00000000, 1'b0, 4'd6}, // R6 1<=NaN
        '{1'b0, 3'd4, 64'h7FC00000_00000000, 64'h7FC00000_00000000, 1'b0, 4'd6}, // R6 NaN>=NaN
        '{1'b0, 3'd1, 64'h7F800000_00000000, 64'h40000000_00000000, 1'b1, 4'd10}, // R10 +inf>2
        '{1'b0, 3'd0, 64'hFF800000_00000000, 64'hC0000000_00000000, 1'b1, 4'd10}, // R10 -inf<-2
        '{1'b0, 3'd6, 64'h3F800000_00000000, 64'h40000000_00000000, 1'b0, 4'd2},  // R2 code 6
        '{1'b0, 3'd7, 64'h40000000_00000000, 64'h40000000_00000000, 1'b0, 4'd2},  // R2 code 7
        '{1'b0, 3'd1, 64'h7F800000_00000001, 64'h40000000_00000000, 1'b1, 4'd3},  // R3 inf, odd ignored
        // double precision
        '{1'b1, 3'd0, 64'h3FF00000_00000000, 64'h3FF00000_00000001, 1'b1, 4'd4}, // R4 1<1+ulp
        '{1'b1, 3'd2, 64'h3FF00000_00000000, 64'h3FF00000_00000001, 1'b0, 4'd4}, // R4 1==1+ulp
        '{1'b1, 3'd1, 64'hBFF00000_00000000, 64'hBFF00000_00000001, 1'b1, 4'd7}, // R7 dbl negatives
        '{1'b1, 3'd2, 64'h00000000_00000000, 64'h80000000_00000000, 1'b1, 4'd5}, // R5 dbl zeros
        '{1'b1, 3'd5, 64'h7FF80000_00000000, 64'h7FF80000_00000000, 1'b1, 4'd6}, // R6 dbl NaN
        '{1'b1, 3'd0, 64'h7FF00000_00000001, 64'h3FF00000_00000000, 1'b0, 4'd6}, // R6 NaN in odd word
        '{1'b1, 3'd3, 64'h40000000_00000000, 64'h40000000_00000000, 1'b1, 4'd1}, // R1 dbl 2<=2
        '{1'b1, 3'd4, 64'hFFF00000_00000000, 64'hC0000000_00000000, 1'b0, 4'd10}, // R10 -inf>=-2
        '{1'b1, 3'd1, 64'h3FF00000_00000000, 64'hBFF00000_00000000, 1'b1, 4'd7}  // R7 1>-1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [2:0]  cond_i = 3'd0;
    logic [31:0] opa_ev_i = '0;
    logic [31:0] opa_od_i = '0;
    logic [31:0] opb_ev_i = '0;
    logic [31:0] opb_od_i = '0;
    logic        flag_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fcmp_flag_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (vld_i),
        .dbl_i    (dbl_i),
        .cond_i   (cond_i),
        .opa_ev_i (opa_ev_i),
        .opa_od_i (opa_od_i),
        .opb_ev_i (opb_ev_i),
        .opb_od_i (opb_od_i),
        .flag_o   (flag_o)
    );

    task automatic check(input int req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: flag=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic d, input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
        dbl_i    = d;
        cond_i   = c;
        opa_ev_i = a[63:32];
        opa_od_i = a[31:0];
        opb_ev_i = b[63:32];
        opb_od_i = b[31:0];
    endtask

    // strobe at a falling edge, result visible at the next falling edge
    task automatic apply(input logic d, input logic [2:0] c, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        drive(d, c, a, b);
        vld_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(9, "reset value", flag_o, 1'b0);           // R9
        rst_n = 1'b1;
        @(negedge clk);
        check(9, "after release", flag_o, 1'b0);         // R9

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].dbl, VECS[i].cond, VECS[i].a, VECS[i].b);
            check(int'(VECS[i].req), $sformatf("vector %0d", i), flag_o, VECS[i].exp);
        end

        // R8: set flag, then churn inputs with strobe low
        apply(1'b0, 3'd5, 64'h3F800000_00000000, 64'h40000000_00000000);
        check(8, "set before hold", flag_o, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive(1'b0, 3'd2, 64'h3F800000_00000000, 64'h40000000_00000000);
        end
        @(negedge clk);
        check(8, "hold high without strobe", flag_o, 1'b1);  // R8
        // R8: value not visible before the capturing edge
        @(negedge clk);
        drive(1'b0, 3'd2, 64'h3F800000_00000000, 64'h40000000_00000000);
        vld_i = 1'b1;
        #2;
        check(8, "no change before edge", flag_o, 1'b1);
        @(negedge clk);
        vld_i = 1'b0;
        check(8, "cleared after strobe", flag_o, 1'b0);
        drive(1'b1, 3'd5, 64'h7FF80000_00000000, 64'h0);
        repeat (3) @(negedge clk);
        check(8, "hold low without strobe", flag_o, 1'b0);

        // R9: reset in mid-run clears a set flag
        apply(1'b1, 3'd4, 64'h40000000_00000000, 64'h3FF00000_00000000);
        check(1, "dbl 2>=1", flag_o, 1'b1);
        #3 rst_n = 1'b0;
        #2;
        check(9, "async clear", flag_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(9, "stays clear after reset", flag_o, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog expired: done=%b expected=%b", done, 1'b1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule